// File: doc/BRIEF.md
# End-of-Interrupt Retirement Unit with Level-Trigger Broadcast

This block is the retirement half of a per-core interrupt controller. It keeps two vector-indexed bit arrays: one marks which vectors are currently being serviced, and the other remembers whether each of those vectors arrived as level-sensitive or edge-sensitive. The delivery side of the controller tells this block through an accept port that a vector has been handed to the core. Software later signals completion with an end-of-interrupt strobe.

On that strobe the unit picks the in-service vector with the largest number, retires it, and, when that vector was level-sensitive, sends its number one cycle later on a broadcast port toward the I/O interrupt routers. A routing unit that sees this broadcast can re-raise a line that is still asserted. A local configuration word holds a controller-enable bit and a suppress bit. When the suppress bit is set, software informs the routers directly and the broadcast is withheld. Arbitration of new interrupts is handled elsewhere.

Top module: `eoi_unit`

## Requirements
- R1: After reset no vector is in service (`svc_any_o`=0), `bc_valid_o` is 0 and every bit of `cfg_o` is 0, so the enable (bit 8) and suppress (bit 12) bits are clear.
- R2: While `cfg_o[8]` is 1, an `acc_valid_i` cycle marks `acc_vector_i` as in service and records its trigger kind from `acc_level_i` (1 = level, 0 = edge). Both take effect at the next clock edge.
- R3: While `cfg_o[8]` is 0, `acc_valid_i` has no effect on the in-service state.
- R4: `svc_top_o` reports the highest-numbered in-service vector. An `eoi_i` cycle with at least one vector in service clears exactly that vector.
- R5: An `eoi_i` cycle with no vector in service changes no state and produces no broadcast.
- R6: A retired vector whose recorded trigger kind is edge produces no broadcast.
- R7: A retired level vector is broadcast only if `cfg_o[12]` is 0 in the `eoi_i` cycle. If that bit is 1, the broadcast is withheld.
- R8: A broadcast is a `bc_valid_o` pulse one cycle wide, raised the cycle after the `eoi_i` cycle, with `bc_vector_o` equal to the retired vector.
- R9: When accept and end-of-interrupt fall in the same cycle, the retirement uses the state from before that edge and the accept is still applied. If both name the same vector, that vector stays in service.
- R10: A `cfg_wr_i` cycle loads `cfg_wdata_i` into the configuration word, visible on `cfg_o` after the edge. Accept gating and suppression in that same cycle use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Vector handed to the core this cycle |
| acc_vector_i | input | 8 | Accepted vector number |
| acc_level_i | input | 1 | 1 = level-sensitive, 0 = edge |
| eoi_i | input | 1 | End-of-interrupt strobe |
| cfg_wr_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Current configuration word |
| svc_any_o | output | 1 | At least one vector in service |
| svc_top_o | output | 8 | Highest-numbered vector in service |
| bc_valid_o | output | 1 | Broadcast pulse |
| bc_vector_o | output | 8 | Broadcast vector number |

## Verification
The bench builds the unit with the full 256-vector space and the grouped priority encoder using 16-bit groups. This puts vectors 0 and 255 within reach, along with every group boundary where the encoder hands off from one group to the next. Directed sequences cover disabled accepts, edge versus level retirement, suppression, retiring from an empty array, and same-cycle collisions. Seeded random traffic then fills and drains many vectors at once.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
   // configuration word bit positions
   localparam int unsigned CFG_EN_BIT   = 8;
   localparam int unsigned CFG_SUPP_BIT = 12;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/eoi_prio_enc.sv
// Highest-set-bit finder; SPLIT picks a flat scan or a two-level grouped scan.
module eoi_prio_enc #(
   parameter int unsigned N     = 256,
   parameter bit          SPLIT = 1'b1,
   parameter int unsigned GRP   = 16,
   localparam int unsigned IW   = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("eoi_prio_enc: N must be a power of two >= 2");
   end

   assign found = |req;

   if (!SPLIT) begin : g_flat
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_grouped
      localparam int unsigned NG  = N / GRP;
      localparam int unsigned GW  = $clog2(GRP);
      localparam int unsigned GSW = $clog2(NG);

      if (GRP < 2 || GRP >= N || (GRP & (GRP - 1)) != 0) begin : g_bad_grp
         $error("eoi_prio_enc: GRP must be a power of two in [2, N)");
      end

      logic [NG-1:0] g_any;
      logic [GW-1:0] g_idx [NG];
      logic [GSW-1:0] gsel;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign g_any[g] = |req[g*GRP +: GRP];
         always_comb begin
            g_idx[g] = '0;
            for (int j = 0; j < GRP; j++) begin
               if (req[g*GRP + j]) g_idx[g] = GW'(j);
            end
         end
      end

      always_comb begin
         gsel = '0;
         for (int g = 0; g < NG; g++) begin
            if (g_any[g]) gsel = GSW'(g);
         end
      end

      assign idx = {gsel, g_idx[gsel]};
   end

   // R4: a reported index must point at a requesting bit
   always_comb begin
      if (found) begin
         enc_hit_chk: assert (req[idx]);
      end
   end
endmodule

// File: rtl/eoi_vec_bank.sv
// In-service and trigger-kind bit arrays, one flop pair per vector.
module eoi_vec_bank #(
   parameter int unsigned N  = 256,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          set_lvl,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   output logic [N-1:0]  isr_q,
   output logic [N-1:0]  tmr_q
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      logic isr_b, tmr_b;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            isr_b <= 1'b0;
            tmr_b <= 1'b0;
         end else if (set_en && set_idx == IW'(b)) begin
            isr_b <= 1'b1;
            tmr_b <= set_lvl;
         end else if (clr_en && clr_idx == IW'(b)) begin
            isr_b <= 1'b0;
         end
      end
      assign isr_q[b] = isr_b;
      assign tmr_q[b] = tmr_b;
   end

   // R2
   set_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> (isr_q[$past(set_idx)] && tmr_q[$past(set_idx)] == $past(set_lvl)));

   // R9
   clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_idx == clr_idx)) |=> !isr_q[$past(clr_idx)]);
endmodule

// File: rtl/eoi_unit.sv
module eoi_unit #(
   parameter int unsigned NUM_VEC    = 256,
   parameter int unsigned CFG_W      = 32,
   parameter bit          PRIO_SPLIT = 1'b1,
   parameter int unsigned PRIO_GRP   = 16,
   localparam int unsigned VW        = $clog2(NUM_VEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid_i,
   input  logic [VW-1:0]    acc_vector_i,
   input  logic             acc_level_i,
   input  logic             eoi_i,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output logic [CFG_W-1:0] cfg_o,
   output logic             svc_any_o,
   output logic [VW-1:0]    svc_top_o,
   output logic             bc_valid_o,
   output logic [VW-1:0]    bc_vector_o
);
   import eoi_pkg::*;

   if (CFG_W <= CFG_SUPP_BIT || CFG_W <= CFG_EN_BIT) begin : g_bad_cfg
      $error("eoi_unit: CFG_W too narrow for control bits");
   end

   logic [CFG_W-1:0]   cfg_q;
   logic [NUM_VEC-1:0] isr_q, tmr_q;
   logic               top_found;
   logic [VW-1:0]      top_idx;
   logic               acc_fire, retire, send;

   // configuration word
   always_ff @(posedge clk) begin
      if (!rst_n)        cfg_q <= '0;
      else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
   end

   assign acc_fire = acc_valid_i && cfg_q[CFG_EN_BIT];
   assign retire   = eoi_i && top_found;
   assign send     = retire && (tmr_q[top_idx] == TRIG_LEVEL) && !cfg_q[CFG_SUPP_BIT];

   eoi_vec_bank #(.N(NUM_VEC)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (acc_fire),
      .set_idx (acc_vector_i),
      .set_lvl (acc_level_i),
      .clr_en  (retire),
      .clr_idx (top_idx),
      .isr_q   (isr_q),
      .tmr_q   (tmr_q)
   );

   eoi_prio_enc #(.N(NUM_VEC), .SPLIT(PRIO_SPLIT), .GRP(PRIO_GRP)) i_enc (
      .req   (isr_q),
      .found (top_found),
      .idx   (top_idx)
   );

   // broadcast register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bc_valid_o  <= 1'b0;
         bc_vector_o <= '0;
      end else begin
         bc_valid_o <= send;
         if (send) bc_vector_o <= top_idx;
      end
   end

   assign cfg_o     = cfg_q;
   assign svc_any_o = top_found;
   assign svc_top_o = top_idx;

   // R8
   bc_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid_o |-> $past(eoi_i));

   // R7
   bc_not_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid_o |-> !$past(cfg_q[CFG_SUPP_BIT]));

   // R5
   empty_eoi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && !svc_any_o) |=> !bc_valid_o);

   // R6
   bc_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid_o |-> $past(tmr_q[svc_top_o]));

   // R3
   disabled_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !cfg_q[CFG_EN_BIT] && !isr_q[acc_vector_i]) |=> !isr_q[$past(acc_vector_i)]);
endmodule

// File: tb/test_eoi_unit.sv
module test_eoi_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid_i = 1'b0;
   logic [7:0]  acc_vector_i = '0;
   logic        acc_level_i = 1'b0;
   logic        eoi_i = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic [31:0] cfg_o;
   logic        svc_any_o;
   logic [7:0]  svc_top_o;
   logic        bc_valid_o;
   logic [7:0]  bc_vector_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   bit [NV-1:0] m_isr, m_tmr;
   bit [31:0]   m_cfg;

   always #(CLK_PERIOD/2) clk = ~clk;

   eoi_unit #(.NUM_VEC(NV), .CFG_W(32), .PRIO_SPLIT(1'b1), .PRIO_GRP(16)) i_eoi_unit (
      .clk(clk), .rst_n(rst_n),
      .acc_valid_i(acc_valid_i), .acc_vector_i(acc_vector_i), .acc_level_i(acc_level_i),
      .eoi_i(eoi_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_o(cfg_o), .svc_any_o(svc_any_o), .svc_top_o(svc_top_o),
      .bc_valid_o(bc_valid_o), .bc_vector_o(bc_vector_o)
   );

   function automatic int hi_bit(bit [NV-1:0] v);
      int r = -1;
      for (int i = 0; i < NV; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag, bit exp_bc, int exp_vec);
      int top = hi_bit(m_isr);
      chk(tag, "bc_valid", bc_valid_o, exp_bc);
      if (exp_bc) chk(tag, "bc_vector", bc_vector_o, exp_vec);
      chk(tag, "svc_any", svc_any_o, top >= 0);
      if (top >= 0) chk(tag, "svc_top", svc_top_o, top);
      chk(tag, "cfg", cfg_o, m_cfg);
   endtask

   task automatic step(string tag, bit eoi, bit acc, int av, bit al, bit cw, bit [31:0] cd);
      bit exp_bc = 1'b0;
      int exp_vec = 0;
      int top;
      @(negedge clk);
      eoi_i = eoi; acc_valid_i = acc; acc_vector_i = 8'(av); acc_level_i = al;
      cfg_wr_i = cw; cfg_wdata_i = cd;
      top = hi_bit(m_isr);
      if (eoi && top >= 0) begin
         exp_bc  = m_tmr[top] && !m_cfg[12];
         exp_vec = top;
         m_isr[top] = 1'b0;
      end
      if (acc && m_cfg[8]) begin
         m_isr[av] = 1'b1;
         m_tmr[av] = al;
      end
      if (cw) m_cfg = cd;
      @(posedge clk);
      #1;
      eoi_i = 1'b0; acc_valid_i = 1'b0; cfg_wr_i = 1'b0;
      check_state(tag, exp_bc, exp_vec);
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_isr = '0; m_tmr = '0; m_cfg = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_state("R1", 0, 0);

      // R3 accept ignored while disabled
      step("R3", 0, 1, 5, 1, 0, 0);
      chk("R3", "svc_any after disabled accept", svc_any_o, 0);

      // R10 enable
      step("R10", 0, 0, 0, 0, 1, 32'h0000_0100);
      // R2 accepts
      step("R2", 0, 1, 40, 1, 0, 0);
      step("R2", 0, 1, 200, 0, 0, 0);
      step("R2", 0, 1, 7, 1, 0, 0);
      chk("R4", "top after accepts", svc_top_o, 200);
      // R6 edge vector retired silently
      step("R6", 1, 0, 0, 0, 0, 0);
      chk("R4", "top after retire", svc_top_o, 40);
      // R8 level vector broadcast, then pulse drops
      step("R8", 1, 0, 0, 0, 0, 0);
      chk("R8", "bc vec 40", bc_vector_o, 40);
      idle("R8");
      // R7 suppression
      step("R10", 0, 0, 0, 0, 1, 32'h0000_1100);
      step("R7", 1, 0, 0, 0, 0, 0);
      chk("R7", "suppressed bc", bc_valid_o, 0);
      step("R10", 0, 0, 0, 0, 1, 32'h0000_0100);
      // R5 empty eoi
      step("R5", 1, 0, 0, 0, 0, 0);
      chk("R5", "empty bc", bc_valid_o, 0);
      // R9 collisions at boundary vectors
      step("R9", 0, 1, 255, 1, 0, 0);
      step("R9", 1, 1, 255, 1, 0, 0);
      chk("R9", "same vec kept", svc_top_o, 255);
      step("R9", 1, 1, 3, 0, 0, 0);
      step("R9", 0, 1, 0, 1, 0, 0);
      step("R4", 1, 0, 0, 0, 0, 0);
      step("R4", 1, 0, 0, 0, 0, 0);
      step("R5", 1, 0, 0, 0, 0, 0);

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         bit e  = ($urandom % 100) < 35;
         bit a  = ($urandom % 100) < 50;
         int v  = ($urandom % 4 == 0) ? int'(($urandom % 4) * 16 + 15) : int'($urandom % NV);
         bit l  = $urandom % 2;
         bit w  = ($urandom % 100) < 4;
         bit [31:0] d = ($urandom & 32'hFFFF_EEFF) | (($urandom % 4 != 0) ? 32'h100 : 0)
                        | (($urandom % 3 == 0) ? 32'h1000 : 0);
         step("R8", e, a, v, l, w, d);
      end
      for (int k = 0; k < 300; k++) step("R4", 1, 0, 0, 0, 0, 0);
      chk("R4", "drained", svc_any_o, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule